// File: doc/BRIEF.md
# Timed Page-Load Buffer Controller

This block gathers the bytes of one flash page into a small on-chip buffer before they are handed to a programming engine. A load phase begins with a command. Byte writes arrive as strobes that carry a byte offset, a page number and a data byte. The bytes may come in any order. The controller keeps an inter-byte idle timer and ends the load when that timer runs out. In a program load, the load also ends at once when the same offset is written twice in a row and the second write carries zero. When a program load ends, the controller pulses a start to the programming engine and waits for its done pulse. The engine reads the page back through a dedicated read port. Offsets that were never written during the load read as all-ones.

A second load mode treats the buffer as scratch storage. In that mode the page number is ignored, the load ends only on the shorter idle window, and no programming starts. A separate read port returns any buffered byte by offset. A clear command erases the whole buffer to all-ones in a single cycle. Both idle windows are parameters counted in clock cycles.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset the controller is idle. `loading`, `busy`, `eng_start`, `page_err` and `prog_fail` are 0, and every offset reads back as FFh.
- R2: During a program load, bytes written at any offsets, in any order, appear at those offsets on the engine read port. Every offset not written since the load began reads FFh.
- R3: A program load accepts a strobe that comes up to IDLE_CYC cycles after the previous strobe or after the start command. If no strobe arrives for IDLE_CYC cycles, `loading` falls and `eng_start` rises in the cycle after the IDLE_CYC-th idle edge.
- R4: In a program load, a strobe with the same offset as the previous stored byte and data 00h ends the load on that edge. `eng_start` is high in the next cycle, the first byte is kept and the 00h is not stored. A same-offset repeat with nonzero data overwrites the byte, and loading continues.
- R5: The page number of the first byte of a program load is latched and presented on `eng_page`. A later byte with a different page number is not stored and sets `page_err`. `page_err` holds until the next load command clears it.
- R6: `eng_start` is a one-cycle pulse. `busy` stays high until `eng_done`, and on that edge `prog_fail` takes the value of `eng_fail` and holds it until the next done.
- R7: In a buffer-only load the page number is ignored and a same-offset 00h write is stored as data. The load ends when no strobe arrives for GAP_CYC cycles, and no `eng_start` is produced.
- R8: A clear command in idle makes all PAGE_BYTES offsets read FFh.
- R9: While the programming engine runs, the load and clear commands are ignored. Byte strobes while idle are ignored.
- R10: `rd_data` shows the byte at `rd_off` as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_cmd | input | 1 | Start a program load (idle only) |
| bufw_cmd | input | 1 | Start a buffer-only load (idle only) |
| clr_cmd | input | 1 | Erase whole buffer to FFh (idle only) |
| wr_en | input | 1 | Byte write strobe |
| wr_page | input | PAGE_W | Page number carried by the strobe |
| wr_off | input | OFF_W | Byte offset inside the page |
| wr_data | input | DATA_W | Byte value |
| rd_off | input | OFF_W | Buffer read offset |
| rd_data | output | DATA_W | Buffer read data, one cycle latency |
| eng_start | output | 1 | One-cycle start to the programming engine |
| eng_page | output | PAGE_W | Page latched on the first byte |
| eng_rd_off | input | OFF_W | Engine read offset |
| eng_rd_data | output | DATA_W | Engine read data, one cycle latency |
| eng_done | input | 1 | Engine finished |
| eng_fail | input | 1 | Engine result, valid with eng_done |
| loading | output | 1 | A load phase is open |
| busy | output | 1 | Controller not idle |
| page_err | output | 1 | A byte of a foreign page was rejected |
| prog_fail | output | 1 | Last engine run failed |

## Verification
Two functions can act on the same clock edge: a byte strobe, and the expiry of the idle window that this strobe would otherwise close. The bench sweeps the gap after a byte from one cycle up to exactly IDLE_CYC cycles. At the limit the strobe lands on the edge where the timer would expire, and the bench expects the strobe to win and the load to stay open. It then confirms that the byte reaches the engine. The terminator strobe and the load end also share a cycle. This is judged by requiring `eng_start` in the very next cycle, with the first value of that offset intact.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PLOAD = 3'd1,
    ST_BLOAD = 3'd2,
    ST_START = 3'd3,
    ST_WAIT  = 3'd4
  } plc_state_e;
endpackage

// File: rtl/plc_gap_timer.sv
module plc_gap_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] last,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (run)       cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && !restart && (cnt_q == last);
endmodule

// File: rtl/plc_page_ram.sv
module plc_page_ram #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  parameter int N_RD   = 2,
  localparam int OFF_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off  [N_RD],
  output logic [DATA_W-1:0] rd_data [N_RD]
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || fill)  vld_q <= '0;
    else if (wr_en)   vld_q[wr_off] <= 1'b1;
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    logic [DATA_W-1:0] dq;
    logic              vq;
    always_ff @(posedge clk) begin
      dq <= mem[rd_off[p]];
    end
    always_ff @(posedge clk) begin
      if (rst) vq <= 1'b0;
      else     vq <= vld_q[rd_off[p]];
    end
    assign rd_data[p] = vq ? dq : {DATA_W{1'b1}};
  end
endmodule

// File: rtl/plc_load_fsm.sv
module plc_load_fsm
  import plc_pkg::*;
#(
  parameter int PAGE_W = 13,
  parameter int OFF_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_cmd,
  input  logic              bufw_cmd,
  input  logic              clr_cmd,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              expire,
  input  logic              eng_done,
  input  logic              eng_fail,
  output logic              store_en,
  output logic              fill,
  output logic              tmr_restart,
  output logic              tmr_run,
  output logic              tmr_long,
  output logic              eng_start,
  output logic [PAGE_W-1:0] eng_page,
  output logic              loading,
  output logic              busy,
  output logic              page_err,
  output logic              prog_fail
);
  plc_state_e        st_q, st_d;
  logic [PAGE_W-1:0] page_q;
  logic              have_first_q;
  logic              have_prev_q;
  logic [OFF_W-1:0]  prev_off_q;
  logic              err_q, fail_q;

  logic in_idle, in_pload, in_bload, hit, pg_bad, term, start_any;

  assign in_idle   = (st_q == ST_IDLE);
  assign in_pload  = (st_q == ST_PLOAD);
  assign in_bload  = (st_q == ST_BLOAD);
  assign hit       = wr_en && (in_pload || in_bload);
  assign pg_bad    = in_pload && have_first_q && (wr_page != page_q);
  assign term      = in_pload && hit && !pg_bad && have_prev_q &&
                     (wr_off == prev_off_q) && (wr_data == '0);
  assign store_en  = hit && !pg_bad && !term;
  assign start_any = in_idle && (prog_cmd || bufw_cmd);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (prog_cmd)      st_d = ST_PLOAD;
        else if (bufw_cmd) st_d = ST_BLOAD;
      end
      ST_PLOAD: if (term || expire) st_d = ST_START;
      ST_BLOAD: if (expire)         st_d = ST_IDLE;
      ST_START:                     st_d = ST_WAIT;
      ST_WAIT:  if (eng_done)       st_d = ST_IDLE;
      default:                      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      page_q       <= '0;
      have_first_q <= 1'b0;
      have_prev_q  <= 1'b0;
      prev_off_q   <= '0;
      err_q        <= 1'b0;
      fail_q       <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_any) begin
        page_q       <= '0;
        have_first_q <= 1'b0;
        have_prev_q  <= 1'b0;
        err_q        <= 1'b0;
      end else begin
        if (in_pload && store_en) begin
          if (!have_first_q) page_q <= wr_page;
          have_first_q <= 1'b1;
          have_prev_q  <= 1'b1;
          prev_off_q   <= wr_off;
        end
        if (hit && pg_bad) err_q <= 1'b1;
      end
      if (st_q == ST_WAIT && eng_done) fail_q <= eng_fail;
    end
  end

  assign fill        = in_idle && (prog_cmd || clr_cmd);
  assign tmr_restart = in_idle || hit;
  assign tmr_run     = in_pload || in_bload;
  assign tmr_long    = in_pload;
  assign eng_start   = (st_q == ST_START);
  assign eng_page    = page_q;
  assign loading     = in_pload || in_bload;
  assign busy        = !in_idle;
  assign page_err    = err_q;
  assign prog_fail   = fail_q;
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl #(
  parameter int PAGE_BYTES = 128,
  parameter int PAGE_W     = 13,
  parameter int DATA_W     = 8,
  parameter int IDLE_CYC   = 10000,
  parameter int GAP_CYC    = 3000,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int MAX_CYC   = (IDLE_CYC > GAP_CYC) ? IDLE_CYC : GAP_CYC,
  localparam int CNT_W     = $clog2(MAX_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_cmd,
  input  logic              bufw_cmd,
  input  logic              clr_cmd,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              eng_start,
  output logic [PAGE_W-1:0] eng_page,
  input  logic [OFF_W-1:0]  eng_rd_off,
  output logic [DATA_W-1:0] eng_rd_data,
  input  logic              eng_done,
  input  logic              eng_fail,
  output logic              loading,
  output logic              busy,
  output logic              page_err,
  output logic              prog_fail
);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST  = CNT_W'(GAP_CYC - 1);

  logic store_en, fill, tmr_restart, tmr_run, tmr_long, expire;
  logic [OFF_W-1:0]  offs  [2];
  logic [DATA_W-1:0] rdata [2];

  plc_load_fsm #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) fsm_i (
    .clk(clk), .rst(rst), .prog_cmd(prog_cmd), .bufw_cmd(bufw_cmd),
    .clr_cmd(clr_cmd), .wr_en(wr_en), .wr_page(wr_page), .wr_off(wr_off),
    .wr_data(wr_data), .expire(expire), .eng_done(eng_done),
    .eng_fail(eng_fail), .store_en(store_en), .fill(fill),
    .tmr_restart(tmr_restart), .tmr_run(tmr_run), .tmr_long(tmr_long),
    .eng_start(eng_start), .eng_page(eng_page), .loading(loading),
    .busy(busy), .page_err(page_err), .prog_fail(prog_fail)
  );

  plc_gap_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk(clk), .rst(rst), .restart(tmr_restart), .run(tmr_run),
    .last(tmr_long ? IDLE_LAST : GAP_LAST), .expire(expire)
  );

  assign offs[0] = rd_off;
  assign offs[1] = eng_rd_off;

  plc_page_ram #(.DEPTH(PAGE_BYTES), .DATA_W(DATA_W), .N_RD(2)) ram_i (
    .clk(clk), .rst(rst), .fill(fill), .wr_en(store_en), .wr_off(wr_off),
    .wr_data(wr_data), .rd_off(offs), .rd_data(rdata)
  );

  assign rd_data     = rdata[0];
  assign eng_rd_data = rdata[1];
endmodule

// File: rtl/plc_checker.sv
module plc_checker #(
  parameter int PAGE_W   = 13,
  parameter int IDLE_CYC = 10000
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              eng_start,
  input logic [PAGE_W-1:0] eng_page,
  input logic              eng_done,
  input logic              loading,
  input logic              busy,
  input logic              prog_fail
);
  logic [31:0] quiet_q;
  always_ff @(posedge clk) begin
    if (rst || !loading || wr_en) quiet_q <= '0;
    else                          quiet_q <= quiet_q + 1;
  end

  // R3
  load_window_chk: assert property (@(posedge clk) disable iff (rst)
    loading |-> (quiet_q < IDLE_CYC));

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  // R6
  start_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> $past(loading));

  // R6
  fail_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(prog_fail) |-> $past(eng_done));

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !loading && $past(busy && !loading)) |-> $stable(eng_page));

  // R9
  engine_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !loading && !eng_done) |=> busy);
endmodule

bind page_load_ctrl plc_checker #(.PAGE_W(PAGE_W), .IDLE_CYC(IDLE_CYC)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .eng_start(eng_start),
  .eng_page(eng_page), .eng_done(eng_done), .loading(loading),
  .busy(busy), .prog_fail(prog_fail)
);

// File: tb/page_load_ctrl_tb_top.sv
`timescale 1ns/1ps
module page_load_ctrl_tb_top;
  localparam int PB = 128;
  localparam int PW = 4;
  localparam int IC = 12;
  localparam int GC = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_cmd = 0, bufw_cmd = 0, clr_cmd = 0, wr_en = 0;
  logic [PW-1:0] wr_page = '0;
  logic [6:0] wr_off = '0, rd_off = '0, eng_rd_off = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, eng_rd_data;
  logic eng_start, eng_done = 0, eng_fail = 0;
  logic [PW-1:0] eng_page;
  logic loading, busy, page_err, prog_fail;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] exp_mem [PB];

  always #5 clk = ~clk;

  page_load_ctrl #(.PAGE_BYTES(PB), .PAGE_W(PW), .DATA_W(8),
                   .IDLE_CYC(IC), .GAP_CYC(GC)) dut_i (
    .clk(clk), .rst(rst), .prog_cmd(prog_cmd), .bufw_cmd(bufw_cmd),
    .clr_cmd(clr_cmd), .wr_en(wr_en), .wr_page(wr_page), .wr_off(wr_off),
    .wr_data(wr_data), .rd_off(rd_off), .rd_data(rd_data),
    .eng_start(eng_start), .eng_page(eng_page), .eng_rd_off(eng_rd_off),
    .eng_rd_data(eng_rd_data), .eng_done(eng_done), .eng_fail(eng_fail),
    .loading(loading), .busy(busy), .page_err(page_err),
    .prog_fail(prog_fail)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wbyte(input int pg, input int off, input int d);
    wr_en = 1; wr_page = PW'(pg); wr_off = 7'(off); wr_data = 8'(d);
    step();
    wr_en = 0;
  endtask

  task automatic pulse_prog(); prog_cmd = 1; step(); prog_cmd = 0; endtask
  task automatic pulse_bufw(); bufw_cmd = 1; step(); bufw_cmd = 0; endtask
  task automatic pulse_clr();  clr_cmd  = 1; step(); clr_cmd  = 0; endtask

  task automatic fill_exp();
    for (int i = 0; i < PB; i++) exp_mem[i] = 8'hFF;
  endtask

  task automatic sweep_rd(input string req);
    int bad = 0; int first = -1;
    for (int i = 0; i < PB; i++) begin
      rd_off = 7'(i); step();
      if (rd_data !== exp_mem[i]) begin bad++; if (first < 0) first = i; end
    end
    chk(bad == 0, req, "buffer read mismatches", bad, 0);
    if (first >= 0) $display("  first bad offset %0d", first);
  endtask

  // call with eng_start just observed high
  task automatic run_engine(input bit fail, input int page, input string req);
    int bad = 0;
    chk(eng_page == PW'(page), req, "eng_page", int'(eng_page), page);
    step();
    chk(!eng_start && busy, "R6", "start one cycle, busy kept",
        {eng_start, busy}, 1);
    for (int i = 0; i < PB; i++) begin
      eng_rd_off = 7'(i); step();
      if (eng_rd_data !== exp_mem[i]) bad++;
    end
    chk(bad == 0, req, "engine page read mismatches", bad, 0);
    chk(busy, "R6", "busy before done", busy, 1);
    eng_done = 1; eng_fail = fail; step(); eng_done = 0; eng_fail = 0;
    chk(!busy && prog_fail == fail, "R6", "idle and fail flag after done",
        {busy, prog_fail}, {1'b0, fail});
  endtask

  task automatic await_timeout(input int lim, input string req);
    int early = 0;
    for (int i = 0; i < lim - 1; i++) begin
      step();
      if (!loading || eng_start) early++;
    end
    chk(early == 0, req, "load open before window end", early, 0);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    fill_exp();
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    chk(!loading && !busy && !eng_start && !page_err && !prog_fail, "R1",
        "idle outputs after reset",
        {loading, busy, eng_start, page_err, prog_fail}, 0);
    sweep_rd("R1");

    // R9: strobe while idle has no effect
    wbyte(2, 5, 8'h11);
    chk(!loading && !busy, "R9", "idle strobe starts nothing", {loading, busy}, 0);
    sweep_rd("R9");

    // R2/R3: scattered program load, ended by idle timeout
    pulse_prog(); fill_exp();
    for (int i = 0; i < 20; i++) begin
      int off = (i * 37 + 3) % PB;
      int d   = (i * 13 + 7) & 8'hFF;
      wbyte(3, off, d); exp_mem[off] = 8'(d);
    end
    await_timeout(IC, "R3");
    chk(eng_start && !loading, "R3", "start after idle window",
        {eng_start, loading}, 2);
    run_engine(1'b0, 3, "R2");

    // R3: gap sweep up to exactly IC cycles, each byte accepted
    pulse_prog(); fill_exp();
    wbyte(1, 0, 8'hA0); exp_mem[0] = 8'hA0;
    for (int g = 1; g <= IC; g++) begin
      repeat (g - 1) step();
      chk(loading, "R3", "load open before strobe at gap", g, 1);
      wbyte(1, g, 8'h40 + g); exp_mem[g] = 8'(8'h40 + g);
    end
    await_timeout(IC, "R3");
    chk(eng_start, "R3", "start after sweep", eng_start, 1);
    // R9: commands ignored while engine runs
    step();
    pulse_clr(); pulse_bufw(); pulse_prog();
    chk(busy && !loading, "R9", "commands ignored in engine phase",
        {busy, loading}, 2);
    run_engine(1'b1, 1, "R3");
    sweep_rd("R9");

    // R4/R5: repeat, foreign page, terminator
    pulse_prog(); fill_exp();
    wbyte(5, 10, 8'h5A);
    wbyte(5, 10, 8'h77); exp_mem[10] = 8'h77;
    chk(loading, "R4", "nonzero repeat keeps load open", loading, 1);
    wbyte(2, 20, 8'h33);
    chk(page_err && loading, "R5", "foreign page flagged",
        {page_err, loading}, 3);
    wbyte(5, 30, 8'h44); exp_mem[30] = 8'h44;
    wbyte(5, 30, 8'h00);
    chk(eng_start && !loading, "R4", "terminator ends load at once",
        {eng_start, loading}, 2);
    run_engine(1'b0, 5, "R4");
    chk(page_err, "R5", "page_err held", page_err, 1);

    // R7: buffer-only load, page ignored, 00 repeat stored
    pulse_bufw();
    chk(!page_err && loading, "R5", "page_err cleared on new load",
        {page_err, loading}, 1);
    for (int i = 0; i < 8; i++) begin
      wbyte(i, 100 + i, 8'hC0 + i); exp_mem[100 + i] = 8'(8'hC0 + i);
    end
    wbyte(9, 50, 8'h12);
    wbyte(3, 50, 8'h00); exp_mem[50] = 8'h00;
    chk(loading, "R7", "00 repeat is data in buffer mode", loading, 1);
    await_timeout(GC, "R7");
    chk(!loading && !busy && !eng_start, "R7", "buffer load ends without start",
        {loading, busy, eng_start}, 0);
    step();
    chk(!eng_start && !busy, "R7", "no start after buffer load",
        {eng_start, busy}, 0);
    sweep_rd("R7");

    // R10: one-cycle read latency
    rd_off = 7'd50; step();
    rd_off = 7'd103; #1;
    chk(rd_data == 8'h00, "R10", "old data before edge", rd_data, 0);
    step();
    chk(rd_data == 8'hC3, "R10", "new data after edge", rd_data, 8'hC3);

    // R8: clear
    pulse_clr(); fill_exp();
    sweep_rd("R8");

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule